// File: doc/BRIEF.md
# Receive DMA Channel with Frame Status Header

This block moves inbound frames from a byte stream into memory buffers. The buffers come from a ring of descriptors that the block only reads. Each descriptor is 64 bits wide and names a buffer address and that buffer's byte count. When a frame starts, the channel fetches the current descriptor and leaves a programmable number of bytes free at the front of the buffer. After that gap it keeps room for a four-byte status header and then writes the frame data. When the last byte has arrived, the channel writes the header, which holds the stored length and the flags.

A frame that fills its buffer carries on in the buffer of the next descriptor. A frame may use at most 16 descriptors. Software posts descriptors by moving a last-posted index, and the channel never fetches the descriptor at that index.

When the channel runs out of descriptors, the overflow-continue setting decides what happens. With it set, the channel discards the rest of the frame, marks the frame as overflowed and keeps running. With it clear, the channel stops and reports an error code. A malformed descriptor also stops the channel, with a separate error code.

Top module: `rx_dma_chan`

## Requirements
- R1: While ctrl_i bit 0 is low, status_o reads 0 (state 0, index 0, error 0), and rx_ready_o, desc_req_o and mem_we_o stay low. Clearing bit 0 returns the channel to this state from any state.
- R2: status_o holds the descriptor index in bits 11:0, the state in bits 15:12 and the error code in bits 19:16. The state codes are 0 disabled, 1 active, 2 idle wait and 3 stopped. An enabled channel with no frame pending reads state 2 and keeps rx_ready_o low.
- R3: A descriptor is read at ring_base_i + 8*index and returned one cycle after desc_req_o. Its bits 12:0 are the byte count, bit 28 marks end of table, and bits 63:32 are the buffer address.
- R4: With offset K taken from ctrl_i bits 7:1, the data bytes of a frame go to consecutive addresses starting at first buffer + K + 4.
- R5: After the last data byte, four header bytes are written at first buffer + K, least significant byte first. The first 16-bit half is the number of bytes stored. The second half holds the flags: bit 7 marks overflow and bits 11:8 hold the number of descriptors used minus one.
- R6: When a buffer fills before the frame ends, the frame continues at offset 0 of the next descriptor's buffer.
- R7: The index advances once for every descriptor used. A descriptor with its end-of-table bit set wraps the index to 0.
- R8: No descriptor is fetched at index == last_ptr_i. A frame that starts with no descriptor available while ctrl_i bit 10 (overflow-continue) is set is consumed and dropped without any memory write, and the channel stays idle.
- R9: With ctrl_i bit 10 clear, a missing descriptor puts the channel into state 3 with error code 2. This applies both at the start of a frame and in mid-frame. The channel remains stopped until it is disabled.
- R10: With ctrl_i bit 10 set, a missing descriptor in mid-frame causes the remaining bytes to be consumed and discarded. The header is still written, with the overflow flag set.
- R11: A frame uses at most 16 descriptors. When the sixteenth buffer fills before the frame ends, the frame is handled as an overflow.
- R12: A first descriptor whose byte count is less than K + 5, or a later descriptor whose byte count is 0, stops the channel with error code 1.
- R13: A byte is taken when rx_valid_i and rx_ready_o are both high. rx_ready_o and desc_req_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 32 | Bit 0 enable, bits 7:1 offset, bit 10 overflow-continue |
| ring_base_i | input | 32 | Byte address of descriptor 0 |
| last_ptr_i | input | 12 | Last-posted index; the descriptor at this index is not used |
| status_o | output | 32 | Index, state and error code |
| rx_valid_i | input | 1 | Stream byte valid |
| rx_data_i | input | 8 | Stream byte |
| rx_last_i | input | 1 | Marks the last byte of a frame |
| rx_ready_o | output | 1 | Channel accepts a byte |
| desc_req_o | output | 1 | Descriptor read request |
| desc_addr_o | output | 32 | Descriptor read address |
| desc_rdata_i | input | 64 | Descriptor, valid one cycle after the request |
| mem_we_o | output | 1 | Byte write strobe |
| mem_addr_o | output | 32 | Byte write address |
| mem_wdata_o | output | 8 | Byte write data |

## Verification
A wrong index, remaining-count or length register does not stay hidden for long. It shows up as data bytes at the wrong address, or as a wrong header, within the same frame. It also shows up as a wrong index in status_o within a few cycles after the frame ends. Each directed scenario therefore checks memory contents byte by byte, checks the header fields and checks the status word. The scenarios cover a single-buffer frame, a frame that spans buffers, end-of-table wrap, overflow with and without continue, the 16-descriptor limit and a malformed descriptor.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [2:0] {
    S_OFF, S_IDLE, S_FETCH, S_DWAIT, S_RECV, S_DROP, S_HDR, S_STOP
  } fsm_e;

  localparam logic [3:0] ST_DISABLED = 4'd0;
  localparam logic [3:0] ST_ACTIVE   = 4'd1;
  localparam logic [3:0] ST_IDLE     = 4'd2;
  localparam logic [3:0] ST_STOPPED  = 4'd3;

  localparam logic [3:0] ERR_NONE  = 4'd0;
  localparam logic [3:0] ERR_PROTO = 4'd1;
  localparam logic [3:0] ERR_OVF   = 4'd2;

  localparam int HDR_BYTES = 4;
endpackage

// File: rtl/rxd_ring_walk.sv
module rxd_ring_walk #(
  parameter int IDX_W = 12,
  parameter int AW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             advance_i,
  input  logic             eot_i,
  input  logic [AW-1:0]    ring_base_i,
  input  logic [IDX_W-1:0] last_ptr_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             avail_o,
  output logic             next_avail_o,
  output logic [AW-1:0]    desc_addr_o
);
  localparam int DESC_SHIFT = 3;

  logic [IDX_W-1:0] idx_q, idx_nxt;

  assign idx_nxt = eot_i ? '0 : idx_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        idx_q <= '0;
    else if (clear_i)   idx_q <= '0;
    else if (advance_i) idx_q <= idx_nxt;
  end

  assign idx_o        = idx_q;
  assign avail_o      = (idx_q != last_ptr_i);
  assign next_avail_o = (idx_nxt != last_ptr_i);
  assign desc_addr_o  = ring_base_i + (AW'(idx_q) << DESC_SHIFT);

  // R7
  eot_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && eot_i && !clear_i) |=> (idx_q == '0));
endmodule

// File: rtl/rxd_hdr_fmt.sv
module rxd_hdr_fmt #(
  parameter int LEN_W = 16,
  parameter int ND_W  = 4
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic             ovf_i,
  input  logic [ND_W-1:0]  ndesc_m1_i,
  input  logic [1:0]       sel_i,
  output logic [7:0]       byte_o
);
  logic [31:0] word;

  // length in 15:0, overflow in 23, descriptors-1 in 27:24
  assign word   = {4'b0, 4'(ndesc_m1_i), ovf_i, 7'b0, 16'(len_i)};
  assign byte_o = word[{sel_i, 3'b000} +: 8];
endmodule

// File: rtl/rx_dma_chan.sv
module rx_dma_chan
  import rxd_pkg::*;
#(
  parameter int AW        = 32,
  parameter int IDX_W     = 12,
  parameter int BC_W      = 13,
  parameter int OFF_W     = 7,
  parameter int LEN_W     = 16,
  parameter int MAX_DESC  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      ctrl_i,
  input  logic [AW-1:0]    ring_base_i,
  input  logic [IDX_W-1:0] last_ptr_i,
  output logic [31:0]      status_o,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_last_i,
  output logic             rx_ready_o,
  output logic             desc_req_o,
  output logic [AW-1:0]    desc_addr_o,
  input  logic [63:0]      desc_rdata_i,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [7:0]       mem_wdata_o
);
  localparam int ND_W = $clog2(MAX_DESC);
  localparam int BW1  = BC_W + 1;

  fsm_e             st_q;
  logic [AW-1:0]    wptr_q, hdr_addr_q;
  logic [BC_W-1:0]  rem_q;
  logic [LEN_W-1:0] len_q;
  logic [ND_W-1:0]  nd_q;
  logic             ovf_q, first_q, eot_q, hdr_pend_q;
  logic [1:0]       hcnt_q;
  logic [3:0]       err_q, st_code;

  logic             en, oc;
  logic [OFF_W-1:0] off;
  logic             accept, buf_full, advance;
  logic [IDX_W-1:0] idx;
  logic             avail, next_avail;
  logic [BC_W-1:0]  d_bc;
  logic [AW-1:0]    d_addr;
  logic [BW1-1:0]   first_need;
  logic [7:0]       hdr_byte;
  logic             unused_bits;

  assign en  = ctrl_i[0];
  assign off = ctrl_i[OFF_W:1];
  assign oc  = ctrl_i[10];
  assign unused_bits = ^{ctrl_i[31:11], ctrl_i[9:8], desc_rdata_i[31:29],
                         desc_rdata_i[27:BC_W]};

  assign d_bc       = desc_rdata_i[BC_W-1:0];
  assign d_addr     = desc_rdata_i[32 +: AW];
  assign first_need = BW1'(off) + BW1'(HDR_BYTES + 1);

  assign rx_ready_o = (st_q == S_RECV) || (st_q == S_DROP);
  assign desc_req_o = (st_q == S_FETCH);
  assign accept     = (st_q == S_RECV) && rx_valid_i;
  assign buf_full   = accept && (rem_q == BC_W'(1));
  assign advance    = accept && (buf_full || rx_last_i);

  rxd_ring_walk #(.IDX_W(IDX_W), .AW(AW)) u_walk (
    .clk_i, .rst_ni,
    .clear_i      (!en),
    .advance_i    (advance),
    .eot_i        (eot_q),
    .ring_base_i,
    .last_ptr_i,
    .idx_o        (idx),
    .avail_o      (avail),
    .next_avail_o (next_avail),
    .desc_addr_o
  );

  rxd_hdr_fmt #(.LEN_W(LEN_W), .ND_W(ND_W)) u_hdr (
    .len_i      (len_q),
    .ovf_i      (ovf_q),
    .ndesc_m1_i (nd_q),
    .sel_i      (hcnt_q),
    .byte_o     (hdr_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_OFF; wptr_q <= '0; hdr_addr_q <= '0; rem_q <= '0;
      len_q <= '0; nd_q <= '0; ovf_q <= 1'b0; first_q <= 1'b0;
      eot_q <= 1'b0; hdr_pend_q <= 1'b0; hcnt_q <= '0; err_q <= ERR_NONE;
    end else if (!en) begin
      st_q <= S_OFF; err_q <= ERR_NONE; eot_q <= 1'b0; hdr_pend_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_OFF: st_q <= S_IDLE;
        S_IDLE: begin
          hdr_pend_q <= 1'b0;
          if (rx_valid_i) begin
            if (avail) begin
              first_q <= 1'b1; nd_q <= '0; len_q <= '0; ovf_q <= 1'b0;
              st_q <= S_FETCH;
            end else if (oc) begin
              st_q <= S_DROP;
            end else begin
              st_q <= S_STOP; err_q <= ERR_OVF;
            end
          end
        end
        S_FETCH: st_q <= S_DWAIT;
        S_DWAIT: begin
          eot_q <= desc_rdata_i[28];
          if (first_q) begin
            if (BW1'(d_bc) < first_need) begin
              st_q <= S_STOP; err_q <= ERR_PROTO;
            end else begin
              hdr_addr_q <= d_addr + AW'(off);
              wptr_q     <= d_addr + AW'(off) + AW'(HDR_BYTES);
              rem_q      <= BC_W'(BW1'(d_bc) - BW1'(off) - BW1'(HDR_BYTES));
              first_q    <= 1'b0;
              hdr_pend_q <= 1'b1;
              st_q       <= S_RECV;
            end
          end else if (d_bc == '0) begin
            st_q <= S_STOP; err_q <= ERR_PROTO;
          end else begin
            wptr_q <= d_addr; rem_q <= d_bc; st_q <= S_RECV;
          end
        end
        S_RECV: begin
          if (accept) begin
            wptr_q <= wptr_q + 1'b1;
            rem_q  <= rem_q - 1'b1;
            len_q  <= len_q + 1'b1;
            if (rx_last_i) begin
              st_q <= S_HDR; hcnt_q <= '0;
            end else if (buf_full) begin
              if (nd_q == ND_W'(MAX_DESC - 1) || !next_avail) begin
                if (oc) begin
                  ovf_q <= 1'b1; st_q <= S_DROP;
                end else begin
                  st_q <= S_STOP; err_q <= ERR_OVF;
                end
              end else begin
                nd_q <= nd_q + 1'b1; st_q <= S_FETCH;
              end
            end
          end
        end
        S_DROP: begin
          if (rx_valid_i && rx_last_i) begin
            st_q   <= hdr_pend_q ? S_HDR : S_IDLE;
            hcnt_q <= '0;
          end
        end
        S_HDR: begin
          hcnt_q <= hcnt_q + 1'b1;
          if (hcnt_q == 2'd3) st_q <= S_IDLE;
        end
        S_STOP: st_q <= S_STOP;
        default: st_q <= S_OFF;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      S_OFF:   st_code = ST_DISABLED;
      S_IDLE:  st_code = ST_IDLE;
      S_STOP:  st_code = ST_STOPPED;
      default: st_code = ST_ACTIVE;
    endcase
  end

  assign status_o    = {12'b0, err_q, st_code, 12'(idx)};
  assign mem_we_o    = accept || (st_q == S_HDR);
  assign mem_addr_o  = (st_q == S_HDR) ? hdr_addr_q + AW'(hcnt_q) : wptr_q;
  assign mem_wdata_o = (st_q == S_HDR) ? hdr_byte : rx_data_i;

  // R9
  stop_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[15:12] == ST_STOPPED && ctrl_i[0]) |=> (status_o[15:12] == ST_STOPPED));

  // R8
  posted_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_req_o |-> (status_o[IDX_W-1:0] != last_ptr_i));

  // R1
  no_write_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ctrl_i[0]) |-> !mem_we_o);

  // R13
  ready_fetch_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_ready_o, desc_req_o}));

  // R1
  off_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ctrl_i[0]) |-> (status_o == 32'd0));
endmodule

// File: tb/tb_rx_dma_chan.sv
module tb_rx_dma_chan;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RING = 32'h0000_1000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] ctrl = '0, ring_base = RING;
  logic [11:0] last_ptr = '0;
  logic [31:0] status;
  logic        rx_valid = 1'b0, rx_last = 1'b0, rx_ready;
  logic [7:0]  rx_data = '0;
  logic        desc_req, mem_we;
  logic [31:0] desc_addr, mem_addr;
  logic [63:0] desc_rd = '0;
  logic [7:0]  mem_wdata;

  logic [7:0]  mem [0:4095];
  logic [63:0] desc_tab [0:31];
  int          wr_cnt = 0, errors = 0, checks = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_dma_chan dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .ring_base_i(ring_base),
    .last_ptr_i(last_ptr), .status_o(status), .rx_valid_i(rx_valid),
    .rx_data_i(rx_data), .rx_last_i(rx_last), .rx_ready_o(rx_ready),
    .desc_req_o(desc_req), .desc_addr_o(desc_addr), .desc_rdata_i(desc_rd),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[11:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (desc_req) desc_rd <= desc_tab[5'((desc_addr - RING) >> 3)];
  end

  function automatic logic [63:0] mk_desc(int bc, bit eot, logic [31:0] addr);
    return {addr, 3'b0, eot, 15'b0, 13'(bc)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drives one frame; gives up if ready stays low for maxw cycles
  task automatic send(int n, logic [7:0] seed, int maxw);
    for (int i = 0; i < n; i++) begin
      int w = 0;
      bit r;
      rx_valid = 1'b1; rx_data = seed + 8'(i); rx_last = (i == n - 1);
      forever begin
        r = rx_ready;
        @(negedge clk);
        if (r) break;
        w++;
        if (w > maxw) begin
          rx_valid = 1'b0; rx_last = 1'b0;
          return;
        end
      end
    end
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < 100; i++) begin
      if (status[15:12] == 4'd2 || status[15:12] == 4'd3) return;
      @(negedge clk);
    end
  endtask

  task automatic fill(int a, int n, logic [7:0] v);
    for (int i = 0; i < n; i++) mem[a + i] = v;
  endtask

  task automatic t_reset();
    chk("R1 status in reset", status, 32'h0);
    chk("R1 ready in reset", {31'b0, rx_ready}, 32'h0);
    chk("R1 we in reset", {31'b0, mem_we}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 disabled status", status, 32'h0);
  endtask

  task automatic t_idle();
    ctrl = 32'h11; last_ptr = 12'd6;
    repeat (3) @(negedge clk);
    chk("R2 idle state", status, 32'h0000_2000);
    chk("R13 no ready when idle", {31'b0, rx_ready}, 32'h0);
  endtask

  task automatic t_single();
    send(10, 8'h30, 50); settle();
    for (int i = 0; i < 10; i++) chk("R4 data", {24'b0, mem[12'h40C + i]}, 32'(8'h30 + i));
    chk("R5 hdr len lo", {24'b0, mem[12'h408]}, 32'h0A);
    chk("R5 hdr len hi", {24'b0, mem[12'h409]}, 32'h00);
    chk("R5 hdr flags", {16'b0, mem[12'h40B], mem[12'h40A]}, 32'h0);
    chk("R7 index after frame", status, 32'h0000_2001);
  endtask

  task automatic t_multi();
    send(7, 8'h50, 50); settle();
    for (int i = 0; i < 4; i++) chk("R6 first buffer", {24'b0, mem[12'h50C + i]}, 32'(8'h50 + i));
    for (int i = 0; i < 3; i++) chk("R6 second buffer", {24'b0, mem[12'h580 + i]}, 32'(8'h54 + i));
    chk("R5 hdr multi", {mem[12'h50B], mem[12'h50A], mem[12'h509], mem[12'h508]}, 32'h0100_0007);
    chk("R7 index after two", status, 32'h0000_2003);
  endtask

  task automatic t_wrap();
    send(3, 8'h70, 50); settle();
    chk("R3 buffer from desc", {24'b0, mem[12'h60C]}, 32'h70);
    chk("R7 eot wrap", status, 32'h0000_2000);
  endtask

  task automatic t_ovf_cont();
    ctrl = 32'h411; last_ptr = 12'd1;
    desc_tab[0] = mk_desc(14, 0, 32'h700);
    fill(12'h700, 32, 8'hEE);
    @(negedge clk);
    send(5, 8'h90, 50); settle();
    chk("R10 stored 0", {24'b0, mem[12'h70C]}, 32'h90);
    chk("R10 stored 1", {24'b0, mem[12'h70D]}, 32'h91);
    chk("R10 discarded", {24'b0, mem[12'h70E]}, 32'hEE);
    chk("R10 hdr ovf", {mem[12'h70B], mem[12'h70A], mem[12'h709], mem[12'h708]}, 32'h0080_0002);
    chk("R10 keeps running", status, 32'h0000_2001);
  endtask

  task automatic t_drop();
    int w0;
    w0 = wr_cnt;
    send(3, 8'hA0, 50); settle();
    repeat (3) @(negedge clk);
    chk("R8 no writes on drop", 32'(wr_cnt - w0), 32'h0);
    chk("R8 still idle", status, 32'h0000_2001);
  endtask

  task automatic t_stop();
    ctrl = 32'h11;
    @(negedge clk);
    send(2, 8'hB0, 8);
    repeat (3) @(negedge clk);
    chk("R9 stopped err2", status, 32'h0002_3001);
    chk("R9 no ready stopped", {31'b0, rx_ready}, 32'h0);
    ctrl = 32'h0;
    @(negedge clk);
    chk("R1 disable clears", status, 32'h0);
  endtask

  task automatic t_proto();
    ctrl = 32'h11; last_ptr = 12'd4;
    desc_tab[0] = mk_desc(12, 0, 32'h700);
    repeat (2) @(negedge clk);
    send(2, 8'hC0, 8);
    settle();
    chk("R12 protocol error", status, 32'h0001_3000);
    ctrl = 32'h0;
    @(negedge clk);
  endtask

  task automatic t_limit();
    desc_tab[0] = mk_desc(13, 0, 32'h800);
    for (int i = 1; i < 32; i++) desc_tab[i] = mk_desc(1, 0, 32'h900 + 32'(i * 16));
    fill(12'hA00, 4, 8'hEE);
    last_ptr = 12'd31; ctrl = 32'h411;
    repeat (2) @(negedge clk);
    send(20, 8'h10, 50); settle();
    chk("R11 first byte", {24'b0, mem[12'h80C]}, 32'h10);
    chk("R11 sixteenth byte", {24'b0, mem[12'h9F0]}, 32'h1F);
    chk("R11 beyond limit", {24'b0, mem[12'hA00]}, 32'hEE);
    chk("R11 hdr", {mem[12'h80B], mem[12'h80A], mem[12'h809], mem[12'h808]}, 32'h0F80_0010);
    chk("R11 index", status, 32'h0000_2010);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    for (int i = 0; i < 32; i++) desc_tab[i] = '0;
    desc_tab[0] = mk_desc(64, 0, 32'h400);
    desc_tab[1] = mk_desc(16, 0, 32'h500);
    desc_tab[2] = mk_desc(5, 0, 32'h580);
    desc_tab[3] = mk_desc(20, 1, 32'h600);
    repeat (3) @(negedge clk);
    t_reset();
    t_idle();
    t_single();
    t_multi();
    t_wrap();
    t_ovf_cont();
    t_drop();
    t_stop();
    t_proto();
    t_limit();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule